// File: doc/BRIEF.md
# Video Memory Address Bus Multiplexer

This block owns the 14-bit address bus that a tile-based picture generator presents to its external video memory. Each dot clock it decides what the bus carries. While a frame is being drawn, the bus carries the address of the current fetch. That fetch is a nametable byte, an attribute byte, or a low or high pattern-plane byte for the background or for a sprite. Outside the drawn area, or when drawing is switched off, the bus simply shows the current VRAM address register.

The block keeps its own dot and scanline counters and decodes the fetch phase from them. It builds every fetch address from a copy of the VRAM address register, taken once at the start of each eight-dot group. A processor write to that register during drawing therefore reaches the bus only at the next group. Address bits 13, 12 and 8 each come from a dedicated selector. The remaining bits come from a shared one. The bus value is registered, so it appears one clock after the dot it belongs to.

Top module: `vaddr_bus_mux`

## Requirements
- R1: A line has 341 dots (0..340) and a frame has 262 lines (0..261). Line 261 is the pre-render line. With the enable high, lines 0..239 and line 261 are active, and on group phases 0-1 (dot mod 8) the bus carries the nametable address 0x2000 | v[11:0].
- R2: On an active line, phases 2-3 carry the attribute address {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]}, but only on dots 0..255 and 320..335. On dots 256..319, phases 2-3 carry the nametable address instead.
- R3: On an active line outside dots 256..319, phases 4-7 carry the background pattern address {0, bg_sel, bg_tile[7:0], plane, v[14:12]}. The plane bit is 0 on phases 4-5 and 1 on phases 6-7.
- R4: On dots 256..319 of an active line in 8x8 sprite mode, phases 4-7 carry the sprite pattern address {0, spr_sel, spr_tile[7:0], plane, v[14:12]}.
- R5: In 8x16 sprite mode (spr_tall = 1), the sprite pattern fetch uses spr_tile[0] as bit 12 and {spr_tile[7:1], 0} as bits 11:4.
- R6: When no line is active (lines 240..260, or the enable low), the bus equals vreg[13:0] of the previous cycle and follows register changes one cycle later.
- R7: During active lines, fetch addresses use the register value sampled at phase 0 of the current group. A change made later in the group is seen first at the next phase 0.
- R8: While a line is active, the bus never carries an address of 0x3000 or above.
- R9: The bus is registered and shows each dot's address one clock after that dot. Reset clears the bus to 0 and the counters to dot 0 of line 0, and selects the register as the bus source.
- R10: On dots 336..340 of an active line, every phase carries the nametable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Drawing enable |
| vreg | input | 15 | VRAM address register: fine row [14:12], table [11:10], coarse row [9:5], coarse column [4:0] |
| bg_tile | input | 8 | Latched background tile index |
| spr_tile | input | 8 | Latched sprite tile index |
| bg_sel | input | 1 | Background pattern-table select |
| spr_sel | input | 1 | Sprite pattern-table select (8x8 mode) |
| spr_tall | input | 1 | 1 = 8x16 sprites |
| vbus | output | 14 | Registered video memory address bus |

## Verification
The bench covers the edges of the fetch windows. It tests a phase-2 dot inside the sprite window, where an attribute address would be wrong, and dot 338, where a design without the late-nametable rule would emit an attribute address. It writes the register in the middle of a group and checks that the pattern fetch still uses the old fine row. A design that reads the register live would show the new one. It checks the last dot of line 239, the first dot of line 240, and the switch back to fetching on the pre-render line. It also loads a palette-range register value during drawing and checks that the bus stays below 0x3000. A mux that forgot to force bit 13 high or gate bit 12 would leak that value.

// File: rtl/vbus_pkg.sv
package vbus_pkg;

  localparam int ADDR_W = 14;
  localparam int VREG_W = 15;

  typedef enum logic [2:0] {
    FK_IDLE   = 3'd0,
    FK_NT     = 3'd1,
    FK_AT     = 3'd2,
    FK_PAT_BG = 3'd3,
    FK_PAT_SP = 3'd4
  } fetch_kind_e;

  function automatic logic [ADDR_W-1:0] nt_addr(input logic [VREG_W-1:0] v);
    return {2'b10, v[11:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] attr_addr(input logic [VREG_W-1:0] v);
    return {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]};
  endfunction

  function automatic logic [ADDR_W-1:0] pat_addr(input logic sel, input logic [7:0] tile,
                                                 input logic plane, input logic [2:0] row);
    return {1'b0, sel, tile, plane, row};
  endfunction

  function automatic logic [7:0] tall_tile(input logic [7:0] t);
    return {t[7:1], 1'b0};
  endfunction

endpackage

// File: rtl/vbus_timing.sv
module vbus_timing #(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  parameter int VISIBLE = 240,
  parameter int TILES   = 32,
  parameter int SPRITES = 8,
  parameter int PREF    = 2,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      render_en,
  output logic [DOT_W-1:0]          dot,
  output logic [LINE_W-1:0]         line,
  output logic                      render_active,
  output logic                      group_start,
  output logic [2:0]                phase,
  output vbus_pkg::fetch_kind_e     kind
);
  import vbus_pkg::*;

  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] LINE_VIS  = LINE_W'(VISIBLE);
  localparam logic [DOT_W-1:0]  SPR_FIRST = DOT_W'(TILES * 8);
  localparam logic [DOT_W-1:0]  SPR_END   = DOT_W'(TILES * 8 + SPRITES * 8);
  localparam logic [DOT_W-1:0]  PREF_END  = DOT_W'(TILES * 8 + SPRITES * 8 + PREF * 8);

  logic in_spr_win, in_attr_win, late_nt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  assign render_active = render_en && ((line < LINE_VIS) || (line == LINE_LAST));
  assign phase         = dot[2:0];
  assign group_start   = (phase == 3'd0);
  assign in_spr_win    = (dot >= SPR_FIRST) && (dot < SPR_END);
  assign late_nt       = (dot >= PREF_END);
  assign in_attr_win   = (dot < SPR_FIRST) || ((dot >= SPR_END) && !late_nt);

  always_comb begin
    if (!render_active)      kind = FK_IDLE;
    else if (late_nt)        kind = FK_NT;
    else if (phase[2])       kind = in_spr_win ? FK_PAT_SP : FK_PAT_BG;
    else if (phase[1] && in_attr_win) kind = FK_AT;
    else                     kind = FK_NT;
  end

endmodule

// File: rtl/vbus_bitsel.sv
module vbus_bitsel (
  input  vbus_pkg::fetch_kind_e  kind,
  input  logic                   render_active,
  input  logic [2:0]             phase,
  input  logic [14:0]            v,
  input  logic [7:0]             bg_tile,
  input  logic [7:0]             spr_tile,
  input  logic                   bg_sel,
  input  logic                   spr_sel,
  input  logic                   spr_tall,
  output logic [13:0]            addr_next
);
  import vbus_pkg::*;

  logic [13:0] shared;
  logic        b13, b12, b8;
  logic [7:0]  spr_idx;
  logic        plane;

  assign plane   = phase[1];
  assign spr_idx = spr_tall ? tall_tile(spr_tile) : spr_tile;

  always_comb begin
    unique case (kind)
      FK_NT:     shared = nt_addr(v);
      FK_AT:     shared = attr_addr(v);
      FK_PAT_BG: shared = pat_addr(bg_sel, bg_tile, plane, v[14:12]);
      FK_PAT_SP: shared = pat_addr(spr_sel, spr_idx, plane, v[14:12]);
      default:   shared = v[13:0];
    endcase
  end

  always_comb begin
    if (kind == FK_PAT_BG || kind == FK_PAT_SP) b13 = 1'b0;
    else                                        b13 = v[13] | render_active;
  end

  always_comb begin
    unique case (kind)
      FK_PAT_BG: b12 = bg_sel;
      FK_PAT_SP: b12 = spr_tall ? spr_tile[0] : spr_sel;
      default:   b12 = v[12] & ~render_active;
    endcase
  end

  always_comb begin
    unique case (kind)
      FK_AT:     b8 = 1'b1;
      FK_PAT_BG: b8 = bg_tile[4];
      FK_PAT_SP: b8 = spr_tile[4];
      default:   b8 = v[8];
    endcase
  end

  assign addr_next = {b13, b12, shared[11:9], b8, shared[7:0]};

endmodule

// File: rtl/vaddr_bus_mux.sv
module vaddr_bus_mux #(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  parameter int VISIBLE = 240,
  parameter int TILES   = 32,
  parameter int SPRITES = 8,
  parameter int PREF    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        render_en,
  input  logic [14:0] vreg,
  input  logic [7:0]  bg_tile,
  input  logic [7:0]  spr_tile,
  input  logic        bg_sel,
  input  logic        spr_sel,
  input  logic        spr_tall,
  output logic [13:0] vbus
);
  import vbus_pkg::*;

  localparam int DOT_W  = $clog2(DOTS);
  localparam int LINE_W = $clog2(LINES);

  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              render_active, group_start;
  logic [2:0]        phase;
  fetch_kind_e       fetch_kind;
  logic [14:0]       v_q, v_use, v_src;
  logic [13:0]       addr_next;

  vbus_timing #(
    .DOTS(DOTS), .LINES(LINES), .VISIBLE(VISIBLE),
    .TILES(TILES), .SPRITES(SPRITES), .PREF(PREF)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .render_en(render_en),
    .dot(dot_cnt), .line(line_cnt), .render_active(render_active),
    .group_start(group_start), .phase(phase), .kind(fetch_kind)
  );

  // Register copy taken once per eight-dot group
  assign v_use = group_start ? vreg : v_q;
  assign v_src = (fetch_kind == FK_IDLE) ? vreg : v_use;

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_use;
  end

  vbus_bitsel u_bitsel (
    .kind(fetch_kind), .render_active(render_active), .phase(phase),
    .v(v_src), .bg_tile(bg_tile), .spr_tile(spr_tile),
    .bg_sel(bg_sel), .spr_sel(spr_sel), .spr_tall(spr_tall),
    .addr_next(addr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vbus <= '0;
    else        vbus <= addr_next;
  end

endmodule

// File: rtl/vaddr_bus_mux_chk.sv
module vaddr_bus_mux_chk #(
  parameter int DOTS  = 341,
  parameter int DOT_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  render_active,
  input vbus_pkg::fetch_kind_e fetch_kind,
  input logic [DOT_W-1:0]      dot_cnt,
  input logic [14:0]           vreg,
  input logic                  bg_sel,
  input logic [7:0]            spr_tile,
  input logic                  spr_tall,
  input logic [13:0]           vbus
);
  import vbus_pkg::*;

  assert_bus_below_palette_R8: assert property (@(posedge clk) disable iff (!rst_n)
    render_active |=> (vbus[13:12] != 2'b11));

  assert_idle_follows_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !render_active |=> (vbus == $past(vreg[13:0])));

  assert_attr_high_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == FK_AT) |=> (vbus[13] && !vbus[12] && vbus[8]));

  assert_bg_table_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == FK_PAT_BG) |=> (!vbus[13] && vbus[12] == $past(bg_sel)));

  assert_tall_bank_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == FK_PAT_SP && spr_tall) |=> (vbus[12] == $past(spr_tile[0])));

  assert_dot_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt == DOT_W'(DOTS - 1)) |=> (dot_cnt == '0));

endmodule

bind vaddr_bus_mux vaddr_bus_mux_chk #(.DOTS(DOTS), .DOT_W(DOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .render_active(render_active),
  .fetch_kind(fetch_kind), .dot_cnt(dot_cnt), .vreg(vreg),
  .bg_sel(bg_sel), .spr_tile(spr_tile), .spr_tall(spr_tall), .vbus(vbus)
);

// File: tb/test_vaddr_bus_mux.sv
module test_vaddr_bus_mux;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        render_en = 1'b0;
  logic [14:0] vreg = 15'h59B6;
  logic [7:0]  bg_tile = 8'h5A;
  logic [7:0]  spr_tile = 8'hC3;
  logic        bg_sel = 1'b1;
  logic        spr_sel = 1'b0;
  logic        spr_tall = 1'b0;
  logic [13:0] vbus;

  int cnt_b = 0;
  int tests = 0;
  int fails = 0;
  int wd = 0;

  always #10 clk = ~clk;

  vaddr_bus_mux i_vaddr_bus_mux (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .vreg(vreg),
    .bg_tile(bg_tile), .spr_tile(spr_tile), .bg_sel(bg_sel),
    .spr_sel(spr_sel), .spr_tall(spr_tall), .vbus(vbus)
  );

  // Cycle count since reset release equals line*341 + dot on the first frame
  always @(posedge clk) cnt_b <= rst_n ? cnt_b + 1 : 0;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  typedef struct packed {
    int          dot;
    logic        ren;
    logic        tall;
    logic [13:0] exp;
    int          req;
  } vec_t;

  // Line 0; v = 0x59B6 (fine row 5), bg tile 0x5A table 1, sprite tile 0xC3 table 0
  localparam vec_t VECS [12] = '{
    '{16,  1'b1, 1'b0, 14'h29B6, 1},   // R1 nametable phase 0
    '{26,  1'b1, 1'b0, 14'h2BDD, 2},   // R2 attribute phase 2
    '{36,  1'b1, 1'b0, 14'h15A5, 3},   // R3 bg low plane
    '{47,  1'b1, 1'b0, 14'h15AD, 3},   // R3 bg high plane
    '{100, 1'b0, 1'b0, 14'h19B6, 6},   // R6 enable low -> register
    '{110, 1'b1, 1'b0, 14'h15AD, 3},   // R3 re-enabled
    '{260, 1'b1, 1'b0, 14'h0C35, 4},   // R4 sprite low plane
    '{279, 1'b1, 1'b0, 14'h0C3D, 4},   // R4 sprite high plane
    '{292, 1'b1, 1'b1, 14'h1C25, 5},   // R5 8x16 bank from tile bit 0
    '{306, 1'b1, 1'b1, 14'h29B6, 2},   // R2 phase 2 in sprite window is nametable
    '{322, 1'b1, 1'b0, 14'h2BDD, 2},   // R2 prefetch attribute
    '{338, 1'b1, 1'b0, 14'h29B6, 10}   // R10 late nametable on phase 2
  };

  task automatic wait_cnt(input int x);
    while (cnt_b < x) @(negedge clk);
  endtask

  task automatic check(input logic [13:0] exp, input string tag);
    tests++;
    if (vbus !== exp) begin
      fails++;
      $display("FAIL %s: vbus=%h expected=%h (cycle %0d)", tag, vbus, exp, cnt_b);
    end
  endtask

  // Check the address produced for state t (registered one edge later)
  task automatic check_at(input int t, input logic [13:0] exp, input string tag);
    wait_cnt(t + 1);
    check(exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(14'h0000, "R9 reset bus");
    rst_n = 1'b1;
    check_at(0, 14'h19B6, "R9 idle source after reset");

    for (int i = 0; i < 12; i++) begin
      wait_cnt(VECS[i].dot - 9);
      render_en = VECS[i].ren;
      spr_tall  = VECS[i].tall;
      check_at(VECS[i].dot, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R7: mid-group write on line 1 (group starting at dot 40)
    wait_cnt(341 + 42);
    vreg = 15'h2123;
    check_at(341 + 43, 14'h2BDD, "R7 attr keeps sampled value");
    check_at(341 + 44, 14'h15A5, "R7 pattern keeps old fine row");
    check_at(341 + 48, 14'h2123, "R7 next group uses new value");

    // R1/R6: boundary between line 239 and line 240
    wait_cnt(400);
    vreg = 15'h0456;
    check_at(239 * 341 + 340, 14'h2456, "R1 last dot of line 239");
    check_at(240 * 341, 14'h0456, "R6 first dot of line 240");
    check_at(240 * 341 + 5, 14'h0456, "R6 post-render holds register");

    // R6: write during blanking reaches the bus next cycle
    wait_cnt(85000);
    vreg = 15'h1ABC;
    check_at(85000, 14'h1ABC, "R6 blank write follows");
    check_at(260 * 341 + 340, 14'h1ABC, "R6 last blank dot");

    // R1: pre-render line fetches again, bit 12 gated, bit 13 forced
    check_at(261 * 341, 14'h2ABC, "R1 pre-render nametable");

    // R8: palette-range register value never reaches the bus while active
    wait_cnt(261 * 341 + 2);
    vreg = 15'h3F00;
    check_at(261 * 341 + 8, 14'h2F00, "R8 palette value stays below 0x3000");
    wait_cnt(261 * 341 + 12);
    render_en = 1'b0;
    check_at(261 * 341 + 12, 14'h3F00, "R6 idle shows palette address");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule